// File: doc/BRIEF.md
# Masked BCD Alarm Match Unit

This block is the alarm section of a real-time clock. Software writes four byte-wide alarm registers through a small register port. The registers hold seconds, minutes, hours and day-of-month in BCD. Bit 7 of each register is a mask flag for that field. The timekeeping counters live elsewhere and supply the current time to the unit as four BCD bytes, along with a one-second tick.

Each write is range-checked in BCD before it is stored. A value that is out of range, or that has a digit above nine, is dropped whole, and the register keeps its previous contents. The mask flags set the repeat period of the alarm: monthly, daily, hourly, every minute or every second. The selected period is shown as an encoded mode output.

On each rising edge of the tick, the unit compares the fields that are not masked against the current time. If they match and interrupts are enabled, it raises a single-cycle interrupt pulse.

Top module: `bcd_alarm_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four alarm registers clear to 0x00, `irq` goes low and `repeat_mode` reads 0 (monthly).
- R2: The register offsets are fixed: 0 is seconds, 1 is minutes, 2 is hours and 3 is date. `rd_data` always shows the full stored byte of the register selected by `rd_addr`, with no delay.
- R3: A seconds or minutes write is accepted only if bits 6:0 form valid BCD: the low nibble is 0 to 9 and the value is 00 to 59. An accepted write stores all 8 bits. A rejected write changes no bit.
- R4: An hours write is accepted only if bits 5:0 form valid BCD 00 to 23. Bits 7:6 take no part in the check. An accepted write stores all 8 bits, and a rejected write changes nothing.
- R5: A date write is accepted only if bits 5:0 form valid BCD 01 to 31. Bits 7:6 take no part in the check. An accepted write stores all 8 bits, and a rejected write changes nothing.
- R6: `repeat_mode` decodes the mask flags as follows:
  - 0 (monthly): no mask is set.
  - 1 (daily): only the date mask is set.
  - 2 (hourly): the date and hours masks are set.
  - 3 (every minute): the date, hours and minutes masks are set.
  - 4 (every second): any other combination.
- R7: In modes 0 to 3, the alarm matches when every unmasked field equals the current time. Seconds and minutes compare bits 6:0, and hours and date compare bits 5:0. In mode 4 the alarm matches on every tick.
- R8: The match is sampled only at a rising edge of `tick`. A matching edge makes `irq` high for exactly the one cycle after that clock edge. A tick held high does not fire again.
- R9: When `irq_en` is low at the sampling edge, no pulse is produced, even on a match.
- R10: `irq` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register offset |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read register offset |
| rd_data | output | 8 | Stored byte at `rd_addr` |
| tick | input | 1 | One-second tick from the timekeeper |
| irq_en | input | 1 | Interrupt enable |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| repeat_mode | output | 3 | Repeat period code (R6) |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The assertions assume that `tick` is a level which the timekeeper raises for at least one clock and lowers again. They also assume that `irq_en` and the time bytes are stable around the sampling edge. The bench drives every input on the falling clock edge and returns `tick` low between events, with one deliberate held-high case. Random write bytes are split between legal BCD values, with random mask and spare bits, and arbitrary bytes. Time bytes are either copies of the stored alarm fields or random values, so that both matching and missing ticks occur in every mode.

// File: rtl/alarm_unit_pkg.sv
// Shared constants, types and per-field rules for the BCD alarm unit.
// Assumes four fields in the fixed order seconds, minutes, hours, date.
package alarm_unit_pkg;

    localparam int NUM_FIELDS = 4;
    localparam int DATA_W     = 8;
    localparam int MASK_BIT   = 7;
    localparam int ADDR_W     = $clog2(NUM_FIELDS);

    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_DATE = 3;

    typedef enum logic [2:0] {
        RPT_MONTH  = 3'd0,
        RPT_DAY    = 3'd1,
        RPT_HOUR   = 3'd2,
        RPT_MINUTE = 3'd3,
        RPT_SECOND = 3'd4
    } repeat_e;

    // Number of value bits below the mask flag that a field decodes
    function automatic int fld_bits(input int idx);
        return (idx == FLD_SEC || idx == FLD_MIN) ? 7 : 6;
    endfunction

    // Smallest legal decoded value of a field
    function automatic int fld_min(input int idx);
        return (idx == FLD_DATE) ? 1 : 0;
    endfunction

    // Largest legal decoded value of a field
    function automatic int fld_max(input int idx);
        case (idx)
            FLD_HOUR: return 23;
            FLD_DATE: return 31;
            default:  return 59;
        endcase
    endfunction

endpackage

// File: rtl/bcd_range_check.sv
// Decides whether the low VAL_BITS of a byte form a valid two-digit BCD
// number within [MIN_VAL, MAX_VAL]. Purely combinational.
// Assumes 5 <= VAL_BITS <= 7 so that the tens digit has 1 to 3 bits.
module bcd_range_check #(
    parameter int VAL_BITS = 7,
    parameter int MIN_VAL  = 0,
    parameter int MAX_VAL  = 59
) (
    input  logic [7:0] byte_in,
    output logic       ok
);
    localparam int TENS_W = VAL_BITS - 4;

    logic [3:0] units;
    logic [3:0] tens;
    logic [7:0] value;

    // Split the field into digits and weigh them into a binary value
    always_comb begin
        units = byte_in[3:0];
        tens  = 4'(byte_in[VAL_BITS-1:4]);
        value = 8'(tens) * 8'd10 + 8'(units);
        ok    = (units <= 4'd9) && (value >= 8'(MIN_VAL)) && (value <= 8'(MAX_VAL));
    end

    logic [TENS_W-1:0] unused_width_probe;
    assign unused_width_probe = byte_in[VAL_BITS-1:4];

endmodule

// File: rtl/alarm_regfile.sv
// Holds the four alarm bytes. A write is stored whole only when its field
// passes the BCD range check for that offset; otherwise nothing changes.
// Assumes synchronous active-low reset.
module alarm_regfile
    import alarm_unit_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_FIELDS-1:0][DATA_W-1:0]  regs
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
            logic value_ok;

            bcd_range_check #(
                .VAL_BITS (fld_bits(gi)),
                .MIN_VAL  (fld_min(gi)),
                .MAX_VAL  (fld_max(gi))
            ) u_check (
                .byte_in (wr_data),
                .ok      (value_ok)
            );

            // Store an accepted byte for this offset, clear on reset
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[gi] <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(gi)) && value_ok)
                    regs[gi] <= wr_data;
            end
        end
    endgenerate

endmodule

// File: rtl/alarm_compare.sv
// Decodes the mask flags into a repeat mode and compares the unmasked
// fields against the current time. Purely combinational.
// Assumes the current-time bytes are BCD in the same layout as the registers.
module alarm_compare
    import alarm_unit_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] regs,
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] now,
    output repeat_e                           mode,
    output logic                              match
);
    logic [NUM_FIELDS-1:0] masked;
    logic [NUM_FIELDS-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
            localparam logic [DATA_W-1:0] CMP_MASK = DATA_W'((1 << fld_bits(gi)) - 1);
            assign masked[gi] = regs[gi][MASK_BIT];
            assign hit[gi]    = masked[gi] || (((regs[gi] ^ now[gi]) & CMP_MASK) == '0);
        end
    endgenerate

    // Map the flag pattern {date, hour, min, sec} onto a repeat period
    always_comb begin
        case ({masked[FLD_DATE], masked[FLD_HOUR], masked[FLD_MIN], masked[FLD_SEC]})
            4'b0000: mode = RPT_MONTH;
            4'b1000: mode = RPT_DAY;
            4'b1100: mode = RPT_HOUR;
            4'b1110: mode = RPT_MINUTE;
            default: mode = RPT_SECOND;
        endcase
    end

    // Every-second mode fires on each tick, the others need all fields to hit
    always_comb begin
        match = (mode == RPT_SECOND) || (&hit);
    end

endmodule

// File: rtl/bcd_alarm_unit.sv
// Top of the BCD alarm unit: register file, comparator, tick edge
// detection and the single-cycle interrupt pulse.
// Assumes tick is synchronous to clk and stays low between seconds.
module bcd_alarm_unit
    import alarm_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic              tick,
    input  logic              irq_en,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [7:0]        now_date,
    output logic [2:0]        repeat_mode,
    output logic              irq
);
    logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_regs;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] now_bus;
    repeat_e                           mode;
    logic                              match;
    logic                              tick_q;
    logic                              tick_rise;

    assign now_bus[FLD_SEC]  = now_sec;
    assign now_bus[FLD_MIN]  = now_min;
    assign now_bus[FLD_HOUR] = now_hour;
    assign now_bus[FLD_DATE] = now_date;

    alarm_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (alarm_regs)
    );

    alarm_compare u_cmp (
        .regs  (alarm_regs),
        .now   (now_bus),
        .mode  (mode),
        .match (match)
    );

    // Present the selected register without delay
    always_comb begin
        rd_data     = alarm_regs[rd_addr];
        repeat_mode = mode;
    end

    // Remember the previous tick level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick;
    end

    assign tick_rise = tick && !tick_q;

    // Fire a one-cycle pulse on a matching, enabled tick edge
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= tick_rise && match && irq_en;
    end

endmodule

// File: rtl/bcd_alarm_unit_chk.sv
// Property checker for the BCD alarm unit, attached by bind.
// Assumes tick and irq_en are driven synchronously to clk.
module bcd_alarm_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        irq_en,
    input logic        wr_en,
    input logic        irq,
    input logic [2:0]  repeat_mode,
    input logic [31:0] alarm_regs
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (alarm_regs == 32'h0 && !irq && repeat_mode == 3'd0));

    // R3
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(alarm_regs));

    // R6
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_mode <= 3'd4);

    // R6
    month_mode_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_mode == 3'd0) |-> (alarm_regs[31] == 1'b0 && alarm_regs[23] == 1'b0 &&
                                   alarm_regs[15] == 1'b0 && alarm_regs[7] == 1'b0));

    // R8
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));

    // R10
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

bind bcd_alarm_unit bcd_alarm_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .irq_en      (irq_en),
    .wr_en       (wr_en),
    .irq         (irq),
    .repeat_mode (repeat_mode),
    .alarm_regs  (alarm_regs)
);

// File: tb/bcd_alarm_unit_tb.sv
// Self-checking bench for bcd_alarm_unit: directed corners plus seeded
// random writes and ticks, checked against a reference model in functions.
module bcd_alarm_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
    logic [2:0] repeat_mode;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] model [4];
    int seed_sink;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_alarm_unit u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .tick (tick), .irq_en (irq_en), .now_sec (now_sec), .now_min (now_min),
        .now_hour (now_hour), .now_date (now_date), .repeat_mode (repeat_mode),
        .irq (irq)
    );

    function automatic bit ref_ok(input int a, input logic [7:0] d);
        int bits = (a < 2) ? 7 : 6;
        int v    = d & ((1 << bits) - 1);
        int u    = v & 15;
        int val  = (v >> 4) * 10 + u;
        int lo   = (a == 3) ? 1 : 0;
        int hi   = (a == 2) ? 23 : (a == 3) ? 31 : 59;
        return (u <= 9) && (val >= lo) && (val <= hi);
    endfunction

    function automatic logic [2:0] ref_mode();
        logic [3:0] m = {model[3][7], model[2][7], model[1][7], model[0][7]};
        case (m)
            4'b0000: return 3'd0;
            4'b1000: return 3'd1;
            4'b1100: return 3'd2;
            4'b1110: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic bit ref_match(input logic [7:0] s, input logic [7:0] mi,
                                     input logic [7:0] h, input logic [7:0] d);
        if (ref_mode() == 3'd4) return 1;
        return (model[0][7] || model[0][6:0] == s[6:0]) &&
               (model[1][7] || model[1][6:0] == mi[6:0]) &&
               (model[2][7] || model[2][5:0] == h[5:0]) &&
               (model[3][7] || model[3][5:0] == d[5:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check_all_regs(input string req);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1;
            chk(req, rd_data, model[a]);
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (ref_ok(a, d)) model[a] = d;
    endtask

    task automatic do_tick(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] d, input bit en, input int hold, input string req);
        logic exp;
        @(negedge clk);
        now_sec = s; now_min = mi; now_hour = h; now_date = d; irq_en = en; tick = 1'b1;
        exp = en && ref_match(s, mi, h, d);
        @(negedge clk);
        chk(req, {7'd0, irq}, {7'd0, exp});
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R8 held tick", {7'd0, irq}, 8'd0);
        end
        tick = 1'b0;
        @(negedge clk);
        chk("R10 pulse ends", {7'd0, irq}, 8'd0);
    endtask

    function automatic logic [7:0] rand_legal(input int a);
        int hi = (a == 2) ? 23 : (a == 3) ? 31 : 59;
        int lo = (a == 3) ? 1 : 0;
        int v  = lo + int'($urandom_range(hi - lo));
        logic [7:0] spare = (a < 2) ? 8'h80 : 8'hC0;
        return to_bcd(v) | (8'($urandom) & spare);
    endfunction

    initial begin
        for (int a = 0; a < 4; a++) model[a] = '0;
        seed_sink = $urandom(32'h5EED_0A1A);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_all_regs("R1 reset regs");
        chk("R1 reset irq", {7'd0, irq}, 8'd0);
        chk("R1 reset mode", {5'd0, repeat_mode}, 3'd0);

        // R3 seconds / minutes boundaries
        do_write(0, 8'h60); check_all_regs("R3 sec 60 rejected");
        do_write(0, 8'h5A); check_all_regs("R3 sec bad digit rejected");
        do_write(0, 8'hD9); check_all_regs("R3 sec 59 with mask accepted");
        do_write(1, 8'h7F); check_all_regs("R3 min 7F rejected");
        do_write(1, 8'h00); check_all_regs("R3 min 00 accepted");
        // R4 hours
        do_write(2, 8'h24); check_all_regs("R4 hour 24 rejected");
        do_write(2, 8'h63); check_all_regs("R4 hour 23 spare bit accepted");
        // R5 date
        do_write(3, 8'h00); check_all_regs("R5 date 00 rejected");
        do_write(3, 8'h32); check_all_regs("R5 date 32 rejected");
        do_write(3, 8'h31); check_all_regs("R5 date 31 accepted");
        // R2 offset order
        do_write(0, 8'h12); do_write(1, 8'h34); do_write(2, 8'h05); do_write(3, 8'h17);
        check_all_regs("R2 offsets");

        // R6 mode combinations and R7 matching
        chk("R6 monthly", {5'd0, repeat_mode}, 3'd0);
        do_tick(8'h12, 8'h34, 8'h05, 8'h17, 1, 0, "R7 monthly hit");
        do_tick(8'h12, 8'h34, 8'h05, 8'h18, 1, 0, "R7 monthly miss");
        do_write(3, 8'h97);
        chk("R6 daily", {5'd0, repeat_mode}, 3'd1);
        do_tick(8'h12, 8'h34, 8'h05, 8'h02, 1, 0, "R7 daily hit");
        do_write(2, 8'h85);
        chk("R6 hourly", {5'd0, repeat_mode}, 3'd2);
        do_tick(8'h12, 8'h34, 8'h21, 8'h02, 1, 0, "R7 hourly hit");
        do_tick(8'h12, 8'h35, 8'h21, 8'h02, 1, 0, "R7 hourly miss");
        do_write(1, 8'hB4);
        chk("R6 minute", {5'd0, repeat_mode}, 3'd3);
        do_tick(8'h12, 8'h00, 8'h00, 8'h01, 1, 0, "R7 minute hit");
        do_write(0, 8'h92);
        chk("R6 second", {5'd0, repeat_mode}, 3'd4);
        do_tick(8'h45, 8'h00, 8'h00, 8'h01, 1, 0, "R7 second mode fires");
        // R8 held tick and R9 disabled
        do_tick(8'h45, 8'h00, 8'h00, 8'h01, 1, 3, "R8 held tick first edge");
        do_tick(8'h45, 8'h00, 8'h00, 8'h01, 0, 0, "R9 irq disabled");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int a = int'($urandom_range(3));
            logic [7:0] d = $urandom_range(1) ? rand_legal(a) : 8'($urandom);
            do_write(a, d);
            rd_addr = 2'(a); #1;
            chk("R3 R4 R5 random write", rd_data, model[a]);
            chk("R6 random mode", {5'd0, repeat_mode}, ref_mode());
            if ($urandom_range(1)) begin
                logic [7:0] s = 8'($urandom), mi = 8'($urandom), h = 8'($urandom), dd = 8'($urandom);
                if ($urandom_range(1)) begin
                    s = model[0]; mi = model[1]; h = model[2]; dd = model[3];
                    if ($urandom_range(3) == 0) s[3:0] = s[3:0] ^ 4'h1;
                end
                do_tick(s, mi, h, dd, ($urandom_range(7) != 0), 0, "R7 R9 random tick");
            end
        end

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 4; a++) model[a] = '0;
        check_all_regs("R1 reset after use");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule